// File: doc/BRIEF.md
# UART Host Register Front-End

This block is the processor-facing register file of a 16450/16550-style serial port. A synchronous bus with separate read and write strobes reaches the receive and transmit holding registers, the interrupt enable register, the FIFO control register, a line status byte and a modem change flag. Which register a bus cycle reaches depends on a 3-bit offset and a divisor-latch select bit. The serial engine is outside this block. It talks to the block at byte level. On the transmit side, the block offers a byte with a load pulse and the engine answers with a done pulse when that byte has left the line. On the receive side, the engine presents a completed byte with a valid pulse and its error flags.

Both directions have two stages. A held transmit byte waits until the engine is idle. A received byte waits in the receive buffer until the host reads it. A single interrupt output combines four sources, and each source is gated by its own enable bit. The FIFO control register only switches FIFO mode, selects the trigger level and flushes. The FIFO storage itself is not part of this block.

Top module: `uart_reg_front`

## Requirements
- R1: With the divisor-latch select bit at 0, offset 0 reaches two separate registers. A read returns the receive buffer. A write loads the transmit holding register. Neither access changes the other register. With the select bit at 1, reads at offsets 0 and 1 return 0x00 and writes there are ignored.
- R2: A byte written to the transmit holding register appears unchanged on `tx_data_o`. Bit 0 is the first bit on the serial line. When the engine is idle, `tx_load_o` is high in the cycle after the write.
- R3: While the engine is busy, `tx_load_o` stays low and the held byte waits. In the cycle after `tx_done_i`, a waiting byte is offered.
- R4: An `rx_valid_i` pulse loads the receive buffer and sets the data-ready bit. Reading the receive buffer clears data-ready.
- R5: If a byte completes while the receive buffer is still unread, the old byte is kept, the new byte is dropped and the overrun bit is set.
- R6: The interrupt enable register sits at offset 1. Its bits are: bit 0 data-available, bit 1 transmit-holding-empty, bit 2 line status, bit 3 modem change. Bits 7..4 always read as 0.
- R7: `irq_o` is the OR of the enabled active sources. When all four enable bits are 0, `irq_o` stays low, and the status bits keep updating.
- R8: The line status byte at offset 5 is laid out as: bit 0 data-ready, bit 1 overrun, bit 2 parity error, bit 3 framing error, bit 4 break, bit 5 holding register empty, bit 6 transmitter fully idle, bit 7 zero. Any of bits 4..1 raises the line-status source. Reading offset 5 clears bits 4..1.
- R9: A `modem_chg_i` pulse sets a pending flag. A read at offset 6 returns that flag in bit 0 and clears it.
- R10: The FIFO control register is write-only at offset 2 for either value of the select bit. A read at offset 2 returns 0x00.
- R11: Writing the FIFO control register with bit 0 = 1 enables FIFO mode. Writing it with bit 0 = 0 disables FIFO mode, empties the receive buffer and the transmit holding register, and pulses both `rx_flush_o` and `tx_flush_o` in the next cycle.
- R12: Bit 1 (receive flush), bit 2 (transmit flush) and bits 7..6 (trigger level, shown on `rx_trig_o`) take effect only when the same write has bit 0 = 1.
- R13: `rx_tmo_i` counts as a data-available source only while FIFO mode is on.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| addr_i | input | 3 | Register offset |
| dlab_i | input | 1 | Divisor-latch select bit |
| wr_i | input | 1 | Write strobe |
| rd_i | input | 1 | Read strobe (side effects at the clock edge) |
| wdata_i | input | 8 | Write data |
| rdata_o | output | 8 | Read data, combinational while rd_i is high |
| tx_data_o | output | 8 | Byte offered to the transmit engine |
| tx_load_o | output | 1 | Engine takes tx_data_o at this clock edge |
| tx_done_i | input | 1 | Engine finished its current byte |
| rx_data_i | input | 8 | Completed received byte |
| rx_valid_i | input | 1 | rx_data_i and the error flags are valid |
| rx_perr_i | input | 1 | Parity error on this byte |
| rx_ferr_i | input | 1 | Framing error on this byte |
| rx_brk_i | input | 1 | Break detected |
| rx_tmo_i | input | 1 | Character timeout condition from the FIFO side |
| modem_chg_i | input | 1 | Modem line change pulse |
| fifo_en_o | output | 1 | FIFO mode on |
| rx_trig_o | output | 2 | Receive trigger level select |
| rx_flush_o | output | 1 | One-cycle receive FIFO flush |
| tx_flush_o | output | 1 | One-cycle transmit FIFO flush |
| irq_o | output | 1 | Interrupt request |

## Verification
The embedded assertions check several behaviours on every cycle. An overrun never changes the held receive byte. A load offer never appears twice while the engine stays busy. A FIFO control write with bit 0 cleared always turns FIFO mode off, pulses both flushes and leaves the trigger level alone. The interrupt-enable read-back and the offset-2 read-back show the required zero bits. Other behaviours are visible only in the bench's directed scenarios: the separation of the two offset-0 registers, the exact cycle of each transmit offer, the masking of every interrupt source while the status byte still changes, the read-to-clear effects on line status and modem change, and the timeout source counting only in FIFO mode.

// File: rtl/uart_fe_pkg.sv
package uart_fe_pkg;
  localparam int unsigned DW = 8;
  localparam int unsigned AW = 3;

  localparam logic [AW-1:0] OFS_DATA = 3'd0;
  localparam logic [AW-1:0] OFS_IER  = 3'd1;
  localparam logic [AW-1:0] OFS_FCR  = 3'd2;
  localparam logic [AW-1:0] OFS_LSR  = 3'd5;
  localparam logic [AW-1:0] OFS_MSR  = 3'd6;

  typedef struct packed {
    logic bi;
    logic fe;
    logic pe;
    logic oe;
  } rx_err_t;
endpackage

// File: rtl/uart_fe_tx.sv
module uart_fe_tx #(
  parameter int unsigned W = 8
) (
  input  logic         clk_i,
  input  logic         rst_ni,
  input  logic         wr_thr_i,
  input  logic [W-1:0] wdata_i,
  input  logic         flush_i,
  input  logic         tx_done_i,
  output logic [W-1:0] tx_data_o,
  output logic         tx_load_o,
  output logic         thre_o,
  output logic         temt_o
);
  logic [W-1:0] thr_q;
  logic         full_q, busy_q;

  assign tx_load_o = full_q & ~busy_q;
  assign tx_data_o = thr_q;
  assign thre_o    = ~full_q;
  assign temt_o    = ~full_q & ~busy_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      thr_q  <= '0;
      full_q <= 1'b0;
      busy_q <= 1'b0;
    end else begin
      if (wr_thr_i) thr_q <= wdata_i;
      // a write in the load cycle refills the holding stage
      if (wr_thr_i)       full_q <= 1'b1;
      else if (flush_i)   full_q <= 1'b0;
      else if (tx_load_o) full_q <= 1'b0;
      if (tx_load_o)      busy_q <= 1'b1;
      else if (tx_done_i) busy_q <= 1'b0;
    end
  end

  assert_one_offer_R3: assert property (@(posedge clk_i) disable iff (!rst_ni)
    tx_load_o && !tx_done_i |=> !tx_load_o);
endmodule

// File: rtl/uart_fe_rx.sv
module uart_fe_rx
  import uart_fe_pkg::*;
#(
  parameter int unsigned W = 8
) (
  input  logic         clk_i,
  input  logic         rst_ni,
  input  logic         rd_rbr_i,
  input  logic         rd_lsr_i,
  input  logic         flush_i,
  input  logic [W-1:0] rx_data_i,
  input  logic         rx_valid_i,
  input  logic         rx_perr_i,
  input  logic         rx_ferr_i,
  input  logic         rx_brk_i,
  output logic [W-1:0] rbr_o,
  output logic         dr_o,
  output rx_err_t      err_o
);
  logic [W-1:0] rbr_q;
  logic         full_q;
  rx_err_t      err_q;
  logic         take, ovr;

  assign take  = rx_valid_i & (~full_q | rd_rbr_i | flush_i);
  assign ovr   = rx_valid_i & full_q & ~rd_rbr_i & ~flush_i;
  assign rbr_o = rbr_q;
  assign dr_o  = full_q;
  assign err_o = err_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      rbr_q  <= '0;
      full_q <= 1'b0;
      err_q  <= '0;
    end else begin
      if (take) rbr_q <= rx_data_i;
      if (take)                     full_q <= 1'b1;
      else if (rd_rbr_i || flush_i) full_q <= 1'b0;
      // new errors win over the clearing read
      err_q.oe <= ovr | (err_q.oe & ~rd_lsr_i);
      err_q.pe <= (take & rx_perr_i) | (err_q.pe & ~rd_lsr_i);
      err_q.fe <= (take & rx_ferr_i) | (err_q.fe & ~rd_lsr_i);
      err_q.bi <= (take & rx_brk_i)  | (err_q.bi & ~rd_lsr_i);
    end
  end

  assert_overrun_keeps_R5: assert property (@(posedge clk_i) disable iff (!rst_ni)
    rx_valid_i && dr_o && !rd_rbr_i && !flush_i |=> $stable(rbr_o) && err_o.oe);
  assert_read_clears_R4: assert property (@(posedge clk_i) disable iff (!rst_ni)
    rd_rbr_i && !rx_valid_i |=> !dr_o);
endmodule

// File: rtl/uart_fe_ctrl.sv
module uart_fe_ctrl (
  input  logic       clk_i,
  input  logic       rst_ni,
  input  logic       wr_ier_i,
  input  logic [3:0] ier_d_i,
  input  logic       wr_fcr_i,
  input  logic [4:0] fcr_d_i,   // {trig[1:0], tx_clr, rx_clr, enable}
  input  logic       rd_msr_i,
  input  logic       modem_chg_i,
  input  logic       dr_i,
  input  logic       tmo_i,
  input  logic       thre_i,
  input  logic       ls_i,
  output logic [3:0] ier_o,
  output logic       msr_pend_o,
  output logic       fifo_en_o,
  output logic [1:0] rx_trig_o,
  output logic       rx_clr_o,
  output logic       tx_clr_o,
  output logic       rx_flush_o,
  output logic       tx_flush_o,
  output logic       irq_o
);
  logic [3:0] ier_q, src;
  logic       fifo_q, msr_q, rxf_q, txf_q;
  logic [1:0] trig_q;
  logic       fcr_on;

  assign fcr_on   = fcr_d_i[0];
  assign rx_clr_o = wr_fcr_i & (~fcr_on | fcr_d_i[1]);
  assign tx_clr_o = wr_fcr_i & (~fcr_on | fcr_d_i[2]);

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      ier_q  <= '0;
      fifo_q <= 1'b0;
      trig_q <= '0;
      msr_q  <= 1'b0;
      rxf_q  <= 1'b0;
      txf_q  <= 1'b0;
    end else begin
      if (wr_ier_i) ier_q <= ier_d_i;
      if (wr_fcr_i) fifo_q <= fcr_on;
      if (wr_fcr_i && fcr_on) trig_q <= fcr_d_i[4:3];
      if (modem_chg_i)   msr_q <= 1'b1;
      else if (rd_msr_i) msr_q <= 1'b0;
      rxf_q <= rx_clr_o;
      txf_q <= tx_clr_o;
    end
  end

  assign src        = {msr_q, ls_i, thre_i, dr_i | (fifo_q & tmo_i)};
  assign irq_o      = |(ier_q & src);
  assign ier_o      = ier_q;
  assign msr_pend_o = msr_q;
  assign fifo_en_o  = fifo_q;
  assign rx_trig_o  = trig_q;
  assign rx_flush_o = rxf_q;
  assign tx_flush_o = txf_q;

  assert_fifo_off_R11: assert property (@(posedge clk_i) disable iff (!rst_ni)
    wr_fcr_i && !fcr_d_i[0] |=> !fifo_en_o && rx_flush_o && tx_flush_o);
  assert_trig_gated_R12: assert property (@(posedge clk_i) disable iff (!rst_ni)
    wr_fcr_i && !fcr_d_i[0] |=> $stable(rx_trig_o));
  assert_modem_set_R9: assert property (@(posedge clk_i) disable iff (!rst_ni)
    modem_chg_i |=> msr_pend_o);
endmodule

// File: rtl/uart_reg_front.sv
module uart_reg_front
  import uart_fe_pkg::*;
(
  input  logic          clk_i,
  input  logic          rst_ni,
  input  logic [AW-1:0] addr_i,
  input  logic          dlab_i,
  input  logic          wr_i,
  input  logic          rd_i,
  input  logic [DW-1:0] wdata_i,
  output logic [DW-1:0] rdata_o,
  output logic [DW-1:0] tx_data_o,
  output logic          tx_load_o,
  input  logic          tx_done_i,
  input  logic [DW-1:0] rx_data_i,
  input  logic          rx_valid_i,
  input  logic          rx_perr_i,
  input  logic          rx_ferr_i,
  input  logic          rx_brk_i,
  input  logic          rx_tmo_i,
  input  logic          modem_chg_i,
  output logic          fifo_en_o,
  output logic [1:0]    rx_trig_o,
  output logic          rx_flush_o,
  output logic          tx_flush_o,
  output logic          irq_o
);
  logic          sel_data, sel_ier;
  logic          wr_thr, rd_rbr, wr_ier, wr_fcr, rd_lsr, rd_msr;
  logic          rx_clr, tx_clr, thre, temt, dr, msr_pend;
  logic [3:0]    ier;
  logic [DW-1:0] rbr, lsr;
  rx_err_t       err;

  assign sel_data = (addr_i == OFS_DATA) & ~dlab_i;
  assign sel_ier  = (addr_i == OFS_IER)  & ~dlab_i;
  assign wr_thr   = wr_i & sel_data;
  assign rd_rbr   = rd_i & sel_data;
  assign wr_ier   = wr_i & sel_ier;
  assign wr_fcr   = wr_i & (addr_i == OFS_FCR);
  assign rd_lsr   = rd_i & (addr_i == OFS_LSR);
  assign rd_msr   = rd_i & (addr_i == OFS_MSR);

  uart_fe_tx #(.W(DW)) u_tx (
    .clk_i, .rst_ni,
    .wr_thr_i (wr_thr),
    .wdata_i,
    .flush_i  (tx_clr),
    .tx_done_i,
    .tx_data_o,
    .tx_load_o,
    .thre_o   (thre),
    .temt_o   (temt)
  );

  uart_fe_rx #(.W(DW)) u_rx (
    .clk_i, .rst_ni,
    .rd_rbr_i (rd_rbr),
    .rd_lsr_i (rd_lsr),
    .flush_i  (rx_clr),
    .rx_data_i, .rx_valid_i, .rx_perr_i, .rx_ferr_i, .rx_brk_i,
    .rbr_o    (rbr),
    .dr_o     (dr),
    .err_o    (err)
  );

  uart_fe_ctrl u_ctrl (
    .clk_i, .rst_ni,
    .wr_ier_i    (wr_ier),
    .ier_d_i     (wdata_i[3:0]),
    .wr_fcr_i    (wr_fcr),
    .fcr_d_i     ({wdata_i[7:6], wdata_i[2:0]}),
    .rd_msr_i    (rd_msr),
    .modem_chg_i,
    .dr_i        (dr),
    .tmo_i       (rx_tmo_i),
    .thre_i      (thre),
    .ls_i        (|err),
    .ier_o       (ier),
    .msr_pend_o  (msr_pend),
    .fifo_en_o,
    .rx_trig_o,
    .rx_clr_o    (rx_clr),
    .tx_clr_o    (tx_clr),
    .rx_flush_o,
    .tx_flush_o,
    .irq_o
  );

  assign lsr = {1'b0, temt, thre, err.bi, err.fe, err.pe, err.oe, dr};

  always_comb begin
    rdata_o = '0;
    if (rd_i) begin
      unique case (addr_i)
        OFS_DATA: rdata_o = dlab_i ? '0 : rbr;
        OFS_IER:  rdata_o = dlab_i ? '0 : {4'h0, ier};
        OFS_LSR:  rdata_o = lsr;
        OFS_MSR:  rdata_o = {{(DW-1){1'b0}}, msr_pend};
        default:  rdata_o = '0;   // FCR is write-only
      endcase
    end
  end

  assert_ier_hi_zero_R6: assert property (@(posedge clk_i) disable iff (!rst_ni)
    rd_i && sel_ier |-> rdata_o[7:4] == 4'h0);
  assert_fcr_wo_R10: assert property (@(posedge clk_i) disable iff (!rst_ni)
    rd_i && addr_i == OFS_FCR |-> rdata_o == '0);
  assert_masked_irq_R7: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $past(wr_ier) && $past(wdata_i[3:0]) == 4'h0 && !wr_ier |-> !irq_o);
endmodule

// File: tb/sim_uart_reg_front.sv
module sim_uart_reg_front;
  localparam int CLK_P = 10;

  logic       clk = 1'b0, rst_n = 1'b0;
  logic [2:0] addr = '0;
  logic       dlab = 1'b0, wr = 1'b0, rd = 1'b0;
  logic [7:0] wdata = '0, rdata, tx_data, rx_data = '0;
  logic       tx_load, tx_done = 1'b0, rx_valid = 1'b0;
  logic       rx_perr = 1'b0, rx_ferr = 1'b0, rx_brk = 1'b0, rx_tmo = 1'b0;
  logic       modem_chg = 1'b0, fifo_en, rx_flush, tx_flush, irq;
  logic [1:0] rx_trig;
  int         n_chk = 0, n_err = 0;
  logic [7:0] v;

  always #(CLK_P/2) clk = ~clk;

  uart_reg_front u0 (
    .clk_i(clk), .rst_ni(rst_n), .addr_i(addr), .dlab_i(dlab), .wr_i(wr),
    .rd_i(rd), .wdata_i(wdata), .rdata_o(rdata), .tx_data_o(tx_data),
    .tx_load_o(tx_load), .tx_done_i(tx_done), .rx_data_i(rx_data),
    .rx_valid_i(rx_valid), .rx_perr_i(rx_perr), .rx_ferr_i(rx_ferr),
    .rx_brk_i(rx_brk), .rx_tmo_i(rx_tmo), .modem_chg_i(modem_chg),
    .fifo_en_o(fifo_en), .rx_trig_o(rx_trig), .rx_flush_o(rx_flush),
    .tx_flush_o(tx_flush), .irq_o(irq)
  );

  task automatic check(input string req, input logic [7:0] act, input logic [7:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_err++;
      $display("FAIL %s: got %02h expected %02h", req, act, exp);
    end
  endtask

  task automatic wr_reg(input logic [2:0] a, input logic [7:0] d, input logic dl);
    addr = a; wdata = d; dlab = dl; wr = 1'b1;
    @(negedge clk);
    wr = 1'b0; dlab = 1'b0;
  endtask

  task automatic rd_reg(input logic [2:0] a, input logic dl, output logic [7:0] d);
    addr = a; dlab = dl; rd = 1'b1;
    #1 d = rdata;
    @(negedge clk);
    rd = 1'b0; dlab = 1'b0;
  endtask

  task automatic rx_byte(input logic [7:0] d, input logic pe, input logic fe, input logic bk);
    rx_data = d; rx_perr = pe; rx_ferr = fe; rx_brk = bk; rx_valid = 1'b1;
    @(negedge clk);
    rx_valid = 1'b0; rx_perr = 1'b0; rx_ferr = 1'b0; rx_brk = 1'b0;
  endtask

  task automatic done_pulse();
    tx_done = 1'b1;
    @(negedge clk);
    tx_done = 1'b0;
  endtask

  task automatic t_reset();
    rd_reg(3'd5, 1'b0, v);
    check("R8 reset status", v, 8'h60);
    check("R7 reset irq", {7'b0, irq}, 8'h00);
    check("R11 reset fifo", {7'b0, fifo_en}, 8'h00);
    check("R2 reset load", {7'b0, tx_load}, 8'h00);
  endtask

  task automatic t_ier();
    wr_reg(3'd1, 8'hFF, 1'b0);
    rd_reg(3'd1, 1'b0, v);
    check("R6 ier readback", v, 8'h0F);
    wr_reg(3'd1, 8'h00, 1'b1);
    rd_reg(3'd1, 1'b0, v);
    check("R1 dlab write ignored", v, 8'h0F);
    rd_reg(3'd1, 1'b1, v);
    check("R1 dlab read zero", v, 8'h00);
    wr_reg(3'd1, 8'h00, 1'b0);
  endtask

  task automatic t_mask();
    check("R7 thre masked", {7'b0, irq}, 8'h00);
    rx_byte(8'h42, 1'b1, 1'b0, 1'b0);
    check("R7 rx masked", {7'b0, irq}, 8'h00);
    rd_reg(3'd5, 1'b0, v);
    check("R7 status updates", v, 8'h65);
    rd_reg(3'd0, 1'b0, v);
    check("R4 rbr", v, 8'h42);
    wr_reg(3'd1, 8'h02, 1'b0);
    check("R7 thre source", {7'b0, irq}, 8'h01);
    wr_reg(3'd1, 8'h00, 1'b0);
  endtask

  task automatic t_tx();
    wr_reg(3'd0, 8'hA5, 1'b0);
    check("R2 offer", {7'b0, tx_load}, 8'h01);
    check("R2 data", tx_data, 8'hA5);
    @(negedge clk);
    check("R3 busy no offer", {7'b0, tx_load}, 8'h00);
    rd_reg(3'd5, 1'b0, v);
    check("R3 thre temt", v, 8'h20);
    wr_reg(3'd0, 8'h3C, 1'b0);
    check("R3 wait", {7'b0, tx_load}, 8'h00);
    rd_reg(3'd5, 1'b0, v);
    check("R3 full", v, 8'h00);
    done_pulse();
    check("R3 offer after done", {7'b0, tx_load}, 8'h01);
    check("R3 data", tx_data, 8'h3C);
    @(negedge clk);
    done_pulse();
    rd_reg(3'd5, 1'b0, v);
    check("R3 idle", v, 8'h60);
  endtask

  task automatic t_rx();
    rx_byte(8'h5A, 1'b0, 1'b0, 1'b0);
    rd_reg(3'd5, 1'b0, v);
    check("R4 data ready", v, 8'h61);
    rd_reg(3'd0, 1'b0, v);
    check("R4 rbr", v, 8'h5A);
    rd_reg(3'd5, 1'b0, v);
    check("R4 dr cleared", v, 8'h60);
    rx_byte(8'h11, 1'b0, 1'b0, 1'b0);
    rx_byte(8'h22, 1'b0, 1'b0, 1'b0);
    rd_reg(3'd5, 1'b0, v);
    check("R5 overrun", v, 8'h63);
    rd_reg(3'd0, 1'b0, v);
    check("R5 old kept", v, 8'h11);
    rx_byte(8'h81, 1'b0, 1'b0, 1'b0);
    wr_reg(3'd0, 8'h0F, 1'b0);
    check("R1 thr", tx_data, 8'h0F);
    rd_reg(3'd0, 1'b0, v);
    check("R1 rbr separate", v, 8'h81);
    done_pulse();
  endtask

  task automatic t_ls();
    wr_reg(3'd1, 8'h04, 1'b0);
    rx_byte(8'h01, 1'b0, 1'b1, 1'b0);
    check("R8 framing irq", {7'b0, irq}, 8'h01);
    rd_reg(3'd5, 1'b0, v);
    check("R8 framing bit", v, 8'h69);
    check("R8 cleared irq", {7'b0, irq}, 8'h00);
    rd_reg(3'd0, 1'b0, v);
    rx_byte(8'h00, 1'b0, 1'b0, 1'b1);
    check("R8 break irq", {7'b0, irq}, 8'h01);
    rd_reg(3'd5, 1'b0, v);
    check("R8 break bit", v, 8'h71);
    rd_reg(3'd0, 1'b0, v);
    wr_reg(3'd1, 8'h00, 1'b0);
  endtask

  task automatic t_msr();
    wr_reg(3'd1, 8'h08, 1'b0);
    check("R9 idle", {7'b0, irq}, 8'h00);
    modem_chg = 1'b1;
    @(negedge clk);
    modem_chg = 1'b0;
    check("R9 irq", {7'b0, irq}, 8'h01);
    rd_reg(3'd6, 1'b0, v);
    check("R9 flag", v, 8'h01);
    check("R9 irq cleared", {7'b0, irq}, 8'h00);
    rd_reg(3'd6, 1'b0, v);
    check("R9 flag cleared", v, 8'h00);
    wr_reg(3'd1, 8'h00, 1'b0);
  endtask

  task automatic t_fcr();
    rd_reg(3'd2, 1'b0, v);
    check("R10 write-only", v, 8'h00);
    wr_reg(3'd2, 8'hC0, 1'b1);
    check("R11 fifo off", {7'b0, fifo_en}, 8'h00);
    check("R11 flush pulses", {6'b0, rx_flush, tx_flush}, 8'h03);
    check("R12 trig ignored", {6'b0, rx_trig}, 8'h00);
    @(negedge clk);
    check("R11 pulse ends", {6'b0, rx_flush, tx_flush}, 8'h00);
    wr_reg(3'd2, 8'hC1, 1'b1);
    check("R11 fifo on", {7'b0, fifo_en}, 8'h01);
    check("R12 trig set", {6'b0, rx_trig}, 8'h03);
    check("R12 no flush", {6'b0, rx_flush, tx_flush}, 8'h00);
    wr_reg(3'd2, 8'h80, 1'b0);
    check("R12 trig kept", {6'b0, rx_trig}, 8'h03);
    wr_reg(3'd2, 8'h01, 1'b0);
    rx_byte(8'h99, 1'b0, 1'b0, 1'b0);
    wr_reg(3'd2, 8'h03, 1'b0);
    check("R12 rx flush only", {6'b0, rx_flush, tx_flush}, 8'h02);
    rd_reg(3'd5, 1'b0, v);
    check("R11 rbr emptied", v, 8'h60);
    wr_reg(3'd1, 8'h01, 1'b0);
    rx_tmo = 1'b1;
    #1 check("R13 timeout fifo", {7'b0, irq}, 8'h01);
    wr_reg(3'd2, 8'h00, 1'b0);
    check("R13 timeout no fifo", {7'b0, irq}, 8'h00);
    rx_tmo = 1'b0;
    wr_reg(3'd1, 8'h00, 1'b0);
  endtask

  initial begin
    #(CLK_P * 100000);
    n_err++;
    $display("FAIL watchdog: got timeout expected completion");
    $display("  Result: errors=%0d of %0d checks", n_err, n_chk + 1);
    $finish;
  end

  initial begin
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
    t_reset();
    t_ier();
    t_mask();
    t_tx();
    t_rx();
    t_ls();
    t_msr();
    t_fcr();
    $display("  Result: errors=%0d of %0d checks", n_err, n_chk);
    $finish;
  end
endmodule